// File: doc/BRIEF.md
# Shared-Multiplier Second-Order Recursive Filter

This block evaluates a second-order recursive (biquad) filter in transposed form: each new sample `x` gives `w = b0*x + s1`, the output becomes `w`, and the two state words advance as `s1' = b1*x - a1*w + s2` and `s2' = b2*x - a2*w`. Rather than one multiplier per coefficient, it has `NMUL` signed multipliers (1, 2 or 3, a parameter). A controller walks the five products through them over several clock cycles. Operand multiplexers feed each multiplier, and two accumulator registers collect the partial sums of the next state.

A sample is offered with a one-cycle `inValid` strobe while `busy` is low. After the fixed schedule, the registered output `outSample` takes the new result and `outValid` pulses. The result is bit-exact with a one-multiplier-per-coefficient implementation that uses the same number format. Samples are 16-bit two's complement, coefficients are Q2.14 and every product is rounded.

Top module: `iir_biquad_shared`

## Requirements
- R1: While `rstN` is low and after it is released, `outSample` is 0, `outValid` is 0 and `busy` is 0, and both state words are 0.
- R2: For each accepted sample the output equals `sat(P(b0,x) + s1)`, with `s1' = wrap(s2 + P(b1,x) - P(a1,w))` and `s2' = wrap(P(b2,x) - P(a2,w))`. The state words are `DW+CW-CF+3` bits (21 by default) and wrap modulo that width.
- R3: Each product is rounded as `P(v,c) = floor((v*c + 2^(CF-1)) / 2^CF)` with CF = 14, so a coefficient value of 16384 stands for 1.0 and exact halves round toward plus infinity.
- R4: The value `w` (and so `outSample`) saturates to the signed `DW`-bit range [-32768, 32767] instead of wrapping.
- R5: If `inValid` is high at a rising edge while `busy` is low, `outValid` is high for exactly one cycle, starting `NSTEP+1` rising edges after that edge, where `NSTEP = ceil(5/NMUL)` (3 by default).
- R6: `busy` is high from the edge that accepts a sample until the edge that raises `outValid`. `inValid` seen while `busy` is high is ignored and changes no later output.
- R7: `outSample` changes only in the cycle in which `outValid` is high and holds its value otherwise.
- R8: With coefficients (b0,b1,b2,a1,a2) = (4096, 8192, 4096, -8192, 4096), the response to the input 32767 followed by zeros equals the R2 to R4 recurrence sample by sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | New-sample strobe, taken only while `busy` is low |
| inSample | input | DW | Input sample, two's complement |
| coefB0 | input | CW | Feed-forward coefficient for the current sample, Q2.14 |
| coefB1 | input | CW | Feed-forward coefficient for one delay, Q2.14 |
| coefB2 | input | CW | Feed-forward coefficient for two delays, Q2.14 |
| coefA1 | input | CW | Feedback coefficient for one delay, Q2.14 |
| coefA2 | input | CW | Feedback coefficient for two delays, Q2.14 |
| busy | output | 1 | A sample is being processed |
| outValid | output | 1 | One-cycle pulse when `outSample` is updated |
| outSample | output | DW | Registered filter output |

## Verification
The checks rest on two assumptions about the inputs. The coefficient ports are read during every multiply cycle of the schedule, so they stay constant while `busy` is high. `inValid` counts only as a single-cycle offer made while the block is idle. The stimulus changes coefficients only after waiting for `busy` to drop. It raises `inValid` for one cycle at a time and holds it low again before the next edge, except for deliberate pulses while `busy` is high, which must have no effect. The latency property counts edges from acceptance, so it relies on each accepted offer being followed by the full schedule before the next.

// File: rtl/iir_pkg.sv
package iir_pkg;

  // Five products per sample: b0*x, b1*x, b2*x, a1*w, a2*w (in schedule order).
  localparam int NUM_PROD = 5;

  // Strobes from control to datapath.
  typedef struct packed {
    logic       load;    // take a new sample, seed the accumulators
    logic       step;    // one multiply cycle
    logic [2:0] slot;    // index of the multiply cycle within the schedule
    logic       commit;  // move accumulators to state, result to output
  } iir_strobe_t;

endpackage

// File: rtl/iir_mul.sv
module iir_mul #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int CF = 14,
  parameter int AW = 21
) (
  input  logic signed [DW-1:0] opA,
  input  logic signed [CW-1:0] opC,
  output logic signed [AW-1:0] prod
);

  localparam int FW = DW + CW;
  localparam logic signed [FW:0] HALF = (FW+1)'(longint'(1) << (CF - 1));

  logic signed [FW-1:0] full;
  logic signed [FW:0]   biased;

  assign full   = opA * opC;
  assign biased = {full[FW-1], full} + HALF;
  // round half up, then drop the fraction bits
  assign prod   = AW'(biased >>> CF);

endmodule

// File: rtl/iir_ctrl.sv
module iir_ctrl
  import iir_pkg::*;
#(
  parameter int NMUL = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        busy,
  output iir_strobe_t strobe
);

  localparam int NSTEP = (NUM_PROD + NMUL - 1) / NMUL;

  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_UPD} state_t;

  state_t     state;
  logic [2:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          stepCnt <= '0;
          if (inValid) state <= ST_MUL;
        end
        ST_MUL: begin
          if (stepCnt == 3'(NSTEP - 1)) begin
            state   <= ST_UPD;
            stepCnt <= '0;
          end else begin
            stepCnt <= stepCnt + 3'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load   = (state == ST_IDLE) && inValid;
    strobe.step   = (state == ST_MUL);
    strobe.slot   = stepCnt;
    strobe.commit = (state == ST_UPD);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/iir_dp.sv
module iir_dp
  import iir_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int CF   = 14,
  parameter int NMUL = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  iir_strobe_t        strobe,
  input  logic signed [DW-1:0] inSample,
  input  logic signed [CW-1:0] coefB0,
  input  logic signed [CW-1:0] coefB1,
  input  logic signed [CW-1:0] coefB2,
  input  logic signed [CW-1:0] coefA1,
  input  logic signed [CW-1:0] coefA2,
  output logic               outValid,
  output logic signed [DW-1:0] outSample
);

  localparam int AW   = DW + CW - CF + 3;
  localparam int SMAX = (2 ** (DW - 1)) - 1;
  localparam int SMIN = -(2 ** (DW - 1));

  logic signed [DW-1:0] xReg, wReg, yReg;
  logic signed [AW-1:0] acc1, acc2, s1, s2;
  logic                 vReg;

  int                   kIdx [NMUL];
  logic signed [AW-1:0] prod [NMUL];
  logic signed [AW-1:0] add1, add2;
  logic signed [AW:0]   wSum;
  logic signed [DW-1:0] wSat;

  // One lane per multiplier: product k = slot*NMUL + lane.
  for (genvar m = 0; m < NMUL; m++) begin : g_lane
    logic signed [DW-1:0] opA;
    logic signed [CW-1:0] opC;

    assign kIdx[m] = int'(strobe.slot) * NMUL + m;

    always_comb begin
      opA = (kIdx[m] < 3) ? xReg : wReg;
      case (kIdx[m])
        0:       opC = coefB0;
        1:       opC = coefB1;
        2:       opC = coefB2;
        3:       opC = coefA1;
        default: opC = coefA2;
      endcase
    end

    iir_mul #(.DW(DW), .CW(CW), .CF(CF), .AW(AW)) u_mul (
      .opA (opA),
      .opC (opC),
      .prod(prod[m])
    );
  end

  // Route each product to the partial sum it belongs to.
  always_comb begin
    add1 = '0;
    add2 = '0;
    for (int m = 0; m < NMUL; m++) begin
      case (kIdx[m])
        1:       add1 = add1 + prod[m];
        3:       add1 = add1 - prod[m];
        2:       add2 = add2 + prod[m];
        4:       add2 = add2 - prod[m];
        default: ;
      endcase
    end
  end

  // w from the b0 product (lane 0, slot 0), saturated to the sample range.
  always_comb begin
    wSum = {prod[0][AW-1], prod[0]} + {s1[AW-1], s1};
    if (int'(wSum) > SMAX)      wSat = DW'(SMAX);
    else if (int'(wSum) < SMIN) wSat = DW'(SMIN);
    else                        wSat = DW'(wSum);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg <= '0;
      wReg <= '0;
      yReg <= '0;
      acc1 <= '0;
      acc2 <= '0;
      s1   <= '0;
      s2   <= '0;
      vReg <= 1'b0;
    end else begin
      vReg <= strobe.commit;
      if (strobe.load) begin
        xReg <= inSample;
        acc1 <= s2;
        acc2 <= '0;
      end
      if (strobe.step) begin
        acc1 <= acc1 + add1;
        acc2 <= acc2 + add2;
        if (strobe.slot == 3'd0) wReg <= wSat;
      end
      if (strobe.commit) begin
        // both state words change in the same edge
        s1   <= acc1;
        s2   <= acc2;
        yReg <= wReg;
      end
    end
  end

  assign outValid  = vReg;
  assign outSample = yReg;

endmodule

// File: rtl/iir_biquad_shared.sv
module iir_biquad_shared
  import iir_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int CF   = 14,
  parameter int NMUL = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic signed [DW-1:0] inSample,
  input  logic signed [CW-1:0] coefB0,
  input  logic signed [CW-1:0] coefB1,
  input  logic signed [CW-1:0] coefB2,
  input  logic signed [CW-1:0] coefA1,
  input  logic signed [CW-1:0] coefA2,
  output logic                 busy,
  output logic                 outValid,
  output logic signed [DW-1:0] outSample
);

  iir_strobe_t strobe;

  iir_ctrl #(.NMUL(NMUL)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .busy   (busy),
    .strobe (strobe)
  );

  iir_dp #(.DW(DW), .CW(CW), .CF(CF), .NMUL(NMUL)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inSample (inSample),
    .coefB0   (coefB0),
    .coefB1   (coefB1),
    .coefB2   (coefB2),
    .coefA1   (coefA1),
    .coefA2   (coefA2),
    .outValid (outValid),
    .outSample(outSample)
  );

endmodule

// File: rtl/iir_checks.sv
module iir_checks
  import iir_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NMUL = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic                 busy,
  input logic                 outValid,
  input logic signed [DW-1:0] outSample,
  input iir_strobe_t          strobe
);

  localparam int NSTEP = (NUM_PROD + NMUL - 1) / NMUL;

  // edges since the accepting edge
  logic [3:0] latCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                  latCnt <= '0;
    else if (inValid && !busy)  latCnt <= 4'd1;
    else if (outValid)          latCnt <= '0;
    else if (latCnt != 4'd0)    latCnt <= latCnt + 4'd1;
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (latCnt == 4'(NSTEP + 2)));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  assert_commit_to_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> outValid);

  assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !busy) |=> busy);

  assert_idle_at_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !busy);

  assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.load);

  assert_hold_output_R7: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outSample));

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.step, strobe.commit}));

endmodule

bind iir_biquad_shared iir_checks #(.DW(DW), .NMUL(NMUL)) u_checks (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .busy     (busy),
  .outValid (outValid),
  .outSample(outSample),
  .strobe   (strobe)
);

// File: tb/tb_iir_biquad_shared.sv
`timescale 1ns/1ps
module tb_iir_biquad_shared;

  localparam int DW    = 16;
  localparam int CW    = 16;
  localparam int CF    = 14;
  localparam int NMUL  = 2;
  localparam int AW    = DW + CW - CF + 3;
  localparam int NSTEP = (5 + NMUL - 1) / NMUL;

  logic clk = 1'b0;
  logic rstN;
  logic inValid;
  logic signed [DW-1:0] inSample;
  logic signed [CW-1:0] cB0, cB1, cB2, cA1, cA2;
  logic busy, outValid;
  logic signed [DW-1:0] outSample;

  always #2.5 clk = ~clk;

  iir_biquad_shared #(.DW(DW), .CW(CW), .CF(CF), .NMUL(NMUL)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .coefB0(cB0), .coefB1(cB1), .coefB2(cB2), .coefA1(cA1), .coefA2(cA2),
    .busy(busy), .outValid(outValid), .outSample(outSample)
  );

  typedef struct {
    logic signed [DW-1:0] y;
    longint               cyc;
    string                tag;
  } exp_t;

  exp_t   q[$];
  int     nChecks = 0;
  int     nFails  = 0;
  longint cyc     = 0;
  bit     done    = 0;
  bit     monOn   = 0;
  longint mS1 = 0, mS2 = 0;
  logic signed [DW-1:0] lastY;
  logic   prevValid;

  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- reference model ----------------
  function automatic longint rnd(longint v, longint c);
    return (v * c + (longint'(1) << (CF - 1))) >>> CF;
  endfunction

  function automatic longint wrapA(longint v);
    longint m;
    m = v & ((longint'(1) << AW) - 1);
    if (m >= (longint'(1) << (AW - 1))) m = m - (longint'(1) << AW);
    return m;
  endfunction

  function automatic longint sat(longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, expv, $time);
    end
  endtask

  // ---------------- driver ----------------
  task automatic sendSample(input logic signed [DW-1:0] x, input string tag);
    longint w, p1, p2, p3, p4;
    exp_t   e;
    @(negedge clk);
    while (busy) @(negedge clk);
    w  = sat(rnd(x, cB0) + mS1);
    p1 = rnd(x, cB1);
    p2 = rnd(x, cB2);
    p3 = rnd(w, cA1);
    p4 = rnd(w, cA2);
    mS1 = wrapA(mS2 + p1 - p3);
    mS2 = wrapA(p2 - p4);
    e.y = DW'(w);
    e.cyc = cyc + NSTEP + 2;
    e.tag = tag;
    q.push_back(e);
    inValid  = 1'b1;
    inSample = x;
    @(negedge clk);
    inValid  = 1'b0;
    inSample = 16'sh5A5A;
    check(busy == 1'b1, "R6 busy after accept", busy, 1);
  endtask

  // pulse inValid while busy: must be ignored (R6)
  task automatic pokeWhileBusy(input logic signed [DW-1:0] x);
    check(busy == 1'b1, "R6 busy during poke", busy, 1);
    inValid  = 1'b1;
    inSample = x;
    @(negedge clk);
    inValid  = 1'b0;
  endtask

  task automatic setCoefs(input int b0, input int b1, input int b2, input int a1, input int a2);
    @(negedge clk);
    while (busy) @(negedge clk);
    cB0 = CW'(b0); cB1 = CW'(b1); cB2 = CW'(b2); cA1 = CW'(a1); cA2 = CW'(a2);
  endtask

  // ---------------- monitor / scoreboard ----------------
  always @(negedge clk) begin
    if (monOn && rstN) begin
      if (outValid) begin
        check(!prevValid, "R5 pulse width", prevValid, 0);
        check(!busy, "R6 idle at valid", busy, 0);
        if (q.size() == 0) begin
          check(1'b0, "R5 unexpected valid", outSample, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(outSample == e.y, e.tag, outSample, e.y);
          check(cyc == e.cyc, "R5 latency", cyc, e.cyc);
        end
        lastY = outSample;
      end else begin
        check(outSample == lastY, "R7 output held", outSample, lastY);
      end
      prevValid = outValid;
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    rstN = 1'b0; inValid = 1'b0; inSample = '0;
    cB0 = '0; cB1 = '0; cB2 = '0; cA1 = '0; cA2 = '0;
    prevValid = 1'b0; lastY = '0;
    repeat (5) @(negedge clk);
    // R1: outputs during reset
    check(outSample == 0, "R1 out in reset", outSample, 0);
    check(outValid == 0,  "R1 valid in reset", outValid, 0);
    check(busy == 0,      "R1 busy in reset", busy, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outSample == 0 && outValid == 0 && busy == 0, "R1 after reset",
          {outSample, outValid, busy}, 0);
    monOn = 1;

    // R8: impulse response
    setCoefs(4096, 8192, 4096, -8192, 4096);
    sendSample(16'sd32767, "R8 impulse");
    for (int i = 0; i < 11; i++) sendSample(16'sd0, "R8 impulse tail");

    // R6: offers while busy are dropped
    sendSample(16'sd1000, "R6 before poke");
    pokeWhileBusy(16'sd20000);
    sendSample(-16'sd500, "R6 after poke");
    @(negedge clk);
    pokeWhileBusy(-16'sd31000);
    sendSample(16'sd0, "R6 after poke 2");

    // R4: saturation both ways
    setCoefs(32767, 0, 0, 0, 0);
    sendSample(16'sd32767, "R4 sat high");
    sendSample(-16'sd32768, "R4 sat low");
    sendSample(16'sd20000, "R4 sat high 2");

    // R3: rounding of exact halves and near-halves
    setCoefs(1, 0, 0, 0, 0);
    sendSample(16'sd0, "R3 flush");
    sendSample(16'sd0, "R3 flush");
    sendSample(16'sd8192, "R3 half up +");
    sendSample(-16'sd8192, "R3 half up -");
    sendSample(16'sd8191, "R3 below half");
    sendSample(-16'sd8193, "R3 above half neg");
    sendSample(16'sd24576, "R3 1.5");

    // R2: random coefficients and samples, state wrapping allowed
    for (int blk = 0; blk < 4; blk++) begin
      setCoefs(int'($urandom_range(0, 32767)) - 16384, int'($urandom_range(0, 32767)) - 16384,
               int'($urandom_range(0, 32767)) - 16384, int'($urandom_range(0, 32767)) - 16384,
               int'($urandom_range(0, 32767)) - 16384);
      for (int i = 0; i < 10; i++)
        sendSample(DW'(int'($urandom_range(0, 65535)) - 32768), "R2 recurrence");
    end

    // drain
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule